// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is an 8-bit arithmetic and logic unit built around a registered accumulator and five status flags. A caller presents an operand byte and a three-bit operation code and raises a write strobe for one clock. On that clock edge the unit combines the accumulator with the operand. It writes the result back to the accumulator, except for compare, which only sets flags. It also loads the sign, zero, nibble-carry, parity and carry flags from the result.

There are eight operations: four arithmetic operations (add, add with carry-in, subtract, subtract with borrow-in), three bitwise operations and a compare. The carry flag has two meanings. After an add it is the carry out of the top bit. After a subtract or a compare it is the borrow. The chained forms take the carry flag held in the register as their incoming bit. The flags are available as single bits and also packed into a status byte with a fixed layout.

Top module: `alu8_acc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator clears to 0x00 and every flag clears, so `status_byte` reads 0x02.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, CMP=7. On a strobed ADD the accumulator becomes (acc + operand) mod 256. On a strobed ADC it becomes (acc + operand + carry flag) mod 256. The carry flag is set when the true sum exceeds 255.
- R3: On a strobed SUB the accumulator becomes (acc - operand) mod 256. On a strobed SBB it becomes (acc - operand - carry flag) mod 256. The carry flag is set exactly when the true difference is negative (a borrow).
- R4: On a strobed AND, OR or XOR the accumulator takes the bitwise result, and both the carry flag and the nibble-carry flag are cleared.
- R5: A strobed CMP sets all five flags exactly as SUB would and leaves the accumulator unchanged.
- R6: After a strobe, the sign flag equals bit 7 of the operation's result, and the zero flag is set exactly when that result is 0x00.
- R7: After a strobe, the parity flag is set when the result holds an even number of ones and cleared when it holds an odd number.
- R8: On an add, the nibble-carry flag is set when the low four bits of acc, operand and carry-in sum above 15. On a subtract or compare, it is set when the low four bits of acc are less than those of the operand plus the borrow-in.
- R9: `status_byte` bit 7 is sign, bit 6 is zero, bit 5 is 0, bit 4 is nibble carry, bit 3 is 0, bit 2 is parity, bit 1 is 1, and bit 0 is carry.
- R10: With `wr_en` low, the accumulator and all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Strobe; performs the operation on this edge |
| op | input | 3 | Operation code |
| operand | input | 8 | Second operand byte |
| acc_out | output | 8 | Accumulator contents |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Nibble-carry flag |
| flag_p | output | 1 | Even-parity flag |
| flag_cy | output | 1 | Carry / borrow flag |
| status_byte | output | 8 | Flags packed in the fixed layout |

## Verification
Each result is due one clock after its strobe. The datapath is combinational, and both the accumulator and the flag register load on the same rising edge that samples `wr_en`. The driver sets the inputs on the falling edge. It queues the expected state for the next rising edge on every cycle, whether or not a strobe is present, so idle cycles are checked as holds. The monitor compares one nanosecond after each rising edge. The chained operations depend on the carry left by the previous strobe, so the reference model carries its own flag state from item to item.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } alu_flags_t;

    localparam alu_flags_t FLAGS_CLEAR = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b0};

    function automatic logic [7:0] pack_status(input alu_flags_t f);
        return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
    endfunction

    function automatic logic is_logic_op(input alu_op_e o);
        return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
    endfunction

    function automatic logic is_sub_op(input alu_op_e o);
        return (o == OP_SUB) || (o == OP_SBB) || (o == OP_CMP);
    endfunction

    function automatic logic uses_carry_in(input alu_op_e o);
        return (o == OP_ADC) || (o == OP_SBB);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             sub,
    output logic [WIDTH-1:0] res,
    output logic             carry,
    output logic             half_carry
);
    localparam int HALF = WIDTH / 2;
    localparam int UPPER = WIDTH - HALF;

    logic [WIDTH-1:0] b_eff;
    logic             c0;
    logic [HALF:0]    lo_sum;
    logic [UPPER:0]   hi_sum;

    // Subtraction is done as a + ~b + ~borrow; raw carries are inverted to borrows.
    always_comb begin
        b_eff  = sub ? ~b : b;
        c0     = sub ? ~cin : cin;
        lo_sum = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, c0};
        hi_sum = {1'b0, a[WIDTH-1:HALF]} + {1'b0, b_eff[WIDTH-1:HALF]}
               + {{UPPER{1'b0}}, lo_sum[HALF]};
        res        = {hi_sum[UPPER-1:0], lo_sum[HALF-1:0]};
        carry      = sub ? ~hi_sum[UPPER] : hi_sum[UPPER];
        half_carry = sub ? ~lo_sum[HALF]  : lo_sum[HALF];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flaggen.sv
module alu8_flaggen
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] res,
    input  logic             arith,
    input  logic             carry,
    input  logic             half_carry,
    output alu_flags_t       flags
);
    always_comb begin
        flags.s  = res[WIDTH-1];
        flags.z  = (res == '0);
        flags.p  = ~^res;
        flags.cy = arith & carry;
        flags.ac = arith & half_carry;
    end
endmodule

// File: rtl/alu8_acc_unit.sv
module alu8_acc_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] operand,
    output logic [WIDTH-1:0] acc_out,
    output logic             flag_s,
    output logic             flag_z,
    output logic             flag_ac,
    output logic             flag_p,
    output logic             flag_cy,
    output logic [7:0]       status_byte
);
    alu_op_e          op_q;
    logic [WIDTH-1:0] acc_r;
    alu_flags_t       flags_r;

    logic [WIDTH-1:0] as_res;
    logic             as_cy;
    logic             as_ac;
    logic [WIDTH-1:0] lg_res;
    logic             arith;
    logic             cin;
    logic [WIDTH-1:0] result;
    alu_flags_t       flags_nx;

    assign op_q  = alu_op_e'(op);
    assign arith = ~is_logic_op(op_q);
    assign cin   = uses_carry_in(op_q) & flags_r.cy;

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a          (acc_r),
        .b          (operand),
        .cin        (cin),
        .sub        (is_sub_op(op_q)),
        .res        (as_res),
        .carry      (as_cy),
        .half_carry (as_ac)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (acc_r),
        .b   (operand),
        .op  (op_q),
        .res (lg_res)
    );

    assign result = arith ? as_res : lg_res;

    alu8_flaggen #(.WIDTH(WIDTH)) u_flags (
        .res        (result),
        .arith      (arith),
        .carry      (as_cy),
        .half_carry (as_ac),
        .flags      (flags_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_r   <= '0;
            flags_r <= FLAGS_CLEAR;
        end else if (wr_en) begin
            flags_r <= flags_nx;
            if (op_q != OP_CMP) begin
                acc_r <= result;
            end
        end
    end

    assign acc_out     = acc_r;
    assign flag_s      = flags_r.s;
    assign flag_z      = flags_r.z;
    assign flag_ac     = flags_r.ac;
    assign flag_p      = flags_r.p;
    assign flag_cy     = flags_r.cy;
    assign status_byte = pack_status(flags_r);

    // Assertions

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(acc_r) && $stable(flags_r)));

    assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_q == OP_CMP) |=> $stable(acc_r));

    assert_logic_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_logic_op(op_q)) |=> (!flags_r.cy && !flags_r.ac));

    assert_sign_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_q != OP_CMP) |=> (flags_r.s == acc_r[WIDTH-1] && flags_r.z == (acc_r == '0)));

    assert_parity_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_q != OP_CMP) |=> (flags_r.p == ~^acc_r));
endmodule

// File: tb/sim_alu8_acc_unit.sv
module sim_alu8_acc_unit;
    typedef struct {
        logic [7:0] acc;
        logic [7:0] st;
        string      tag;
    } exp_t;

    logic       clk = 0;
    logic       rst = 1;
    logic       wr_en = 0;
    logic [2:0] op = 0;
    logic [7:0] operand = 0;
    logic [7:0] acc_out;
    logic       flag_s, flag_z, flag_ac, flag_p, flag_cy;
    logic [7:0] status_byte;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t q[$];

    // model state
    logic [7:0] m_acc = 0;
    logic m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

    always #2 clk = ~clk;

    alu8_acc_unit u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .op(op), .operand(operand),
        .acc_out(acc_out), .flag_s(flag_s), .flag_z(flag_z), .flag_ac(flag_ac),
        .flag_p(flag_p), .flag_cy(flag_cy), .status_byte(status_byte)
    );

    function automatic logic [7:0] mk_status();
        return {m_s, m_z, 1'b0, m_ac, 1'b0, m_p, 1'b1, m_cy};
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Driver: one call per cycle; computes expected state and queues it.
    task automatic drive(bit en, logic [2:0] o, logic [7:0] b);
        int r;
        int lo;
        int ci;
        logic [7:0] res;
        string tag;
        @(negedge clk);
        wr_en = en; op = o; operand = b;
        if (!en) begin
            tag = "R10 hold";
        end else begin
            ci = (o == 3'd1 || o == 3'd3) ? int'(m_cy) : 0;
            case (o)
                3'd0, 3'd1: begin
                    r = int'(m_acc) + int'(b) + ci;
                    lo = int'(m_acc[3:0]) + int'(b[3:0]) + ci;
                    m_cy = (r > 255); m_ac = (lo > 15);
                    tag = (o == 3'd0) ? "R2 add" : "R2 adc";
                end
                3'd2, 3'd3, 3'd7: begin
                    r = int'(m_acc) - int'(b) - ci;
                    lo = int'(m_acc[3:0]) - int'(b[3:0]) - ci;
                    m_cy = (r < 0); m_ac = (lo < 0);
                    tag = (o == 3'd7) ? "R5 cmp" : "R3 sub";
                end
                default: begin
                    if (o == 3'd4) r = int'(m_acc & b);
                    else if (o == 3'd5) r = int'(m_acc | b);
                    else r = int'(m_acc ^ b);
                    m_cy = 0; m_ac = 0;
                    tag = "R4 logic";
                end
            endcase
            res = r[7:0];
            m_s = res[7];
            m_z = (res == 8'h00);
            m_p = ~^res;
            if (o != 3'd7) m_acc = res;
        end
        q.push_back('{acc: m_acc, st: mk_status(), tag: tag});
    endtask

    // Monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check8({e.tag, " acc"}, acc_out, e.acc);
            check8("R9 status_byte", status_byte, e.st);
            check8("R6 sign", {7'd0, flag_s}, {7'd0, e.st[7]});
            check8("R6 zero", {7'd0, flag_z}, {7'd0, e.st[6]});
            check8("R8 nibble carry", {7'd0, flag_ac}, {7'd0, e.st[4]});
            check8("R7 parity", {7'd0, flag_p}, {7'd0, e.st[2]});
            check8({e.tag, " carry"}, {7'd0, flag_cy}, {7'd0, e.st[0]});
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check8("R1 reset acc", acc_out, 8'h00);
        check8("R1 reset status", status_byte, 8'h02);

        drive(1, 3'd0, 8'h0F);  // R2: 0F
        drive(1, 3'd0, 8'h01);  // R8: nibble carry, 10
        drive(1, 3'd0, 8'hF0);  // R2: wraps to 00, carry, zero
        drive(1, 3'd1, 8'h05);  // R2: adc uses carry -> 06
        drive(1, 3'd2, 8'h07);  // R3: borrow -> FF
        drive(1, 3'd3, 8'h0F);  // R3: sbb with borrow -> EF
        drive(0, 3'd2, 8'h55);  // R10: ignored
        drive(0, 3'd0, 8'hAA);  // R10
        drive(1, 3'd7, 8'hEF);  // R5: equal -> zero, acc stays
        drive(1, 3'd7, 8'hF0);  // R5: borrow
        drive(1, 3'd4, 8'h3C);  // R4
        drive(1, 3'd5, 8'h81);  // R4
        drive(1, 3'd6, 8'hFF);  // R4
        for (int i = 0; i < 200; i++) begin
            drive(($urandom % 4) != 0, 3'($urandom % 8), 8'($urandom));
        end
        drive(0, 3'd0, 8'h00);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check8("R1 reset after run acc", acc_out, 8'h00);
        check8("R1 reset after run status", status_byte, 8'h02);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule